// File: doc/BRIEF.md
# Dual-Role Serial Peripheral Port

This block is a byte-wide serial peripheral port. It can run as the clocking end of an SPI link or as the clocked end. A CPU reaches it through a small word-addressed register port. The port has three registers:

- a configuration register, which picks the role, the clock polarity, the clock phase and the rate code;
- a status register, which holds the frame-done flag, the collision flag and the double-speed bit;
- a data register. Writing it loads the outgoing byte. Reading it returns the last byte received.

In master role the block makes SCK from the system clock. The half period is set by the rate code and the double-speed bit. A frame starts when the data register is written while the block is idle.

In slave role the block passes SCK, MOSI and the select line through synchronisers and shifts on the edges it detects. The system clock must be at least four times the SCK rate. A select line pulled low while the block is master is a mode fault. On a mode fault the block drops to slave role by itself and raises the frame-done flag.

Top module: `spi_port`

## Requirements
- R1: After reset the configuration, status and data registers read 0, sck_o is 0, and sck_oe, mosi_oe and miso_oe are 0.
- R2: The configuration register (address 0) holds the role in bit 4 (1 = master), the clock polarity (CPOL) in bit 3, the clock phase (CPHA) in bit 2 and the rate code in bits 1:0. Bits 7:5 read 0.
- R3: The status register (address 1) shows the frame-done flag in bit 7 and the collision flag in bit 6. Neither flag can be written. Bits 5:1 read 0 and bit 0 is the writable double-speed bit.
- R4: In master role, SCK toggles every H system cycles, where H is 2, 8, 32 or 64 for rate codes 0 to 3 with double speed off, and 1, 4, 16 or 32 with it on. The frame-done flag reads 1 exactly 16·H cycles after the clock edge that took the data write, and 0 one cycle earlier.
- R5: sck_o rests at the CPOL level while no frame is in progress. A frame makes exactly 16 SCK transitions.
- R6: Bits go out and come in MSB first. With CPHA=0 the line is sampled on the leading edge (the transition away from the rest level) and changed on the trailing edge. With CPHA=1 it is changed on the leading edge and sampled on the trailing edge.
- R7: When a frame ends, the received byte is copied into a read buffer, which address 2 returns.
- R8: Writing the data register during a frame sets the collision flag. The byte being shifted is not changed.
- R9: Both flags clear when the status register is read while a flag is set and address 2 is then accessed. An access to address 2 without that status read leaves the flags set.
- R10: When the synchronised select line is low while the role is master, the role bit clears, the frame-done flag sets and SCK/MOSI drive is released. The role stays slave until it is written again.
- R11: In slave role with the select line low, the block receives from MOSI and sends its loaded byte on MISO, in all four CPOL/CPHA modes. It raises the frame-done flag after the 16th SCK edge.
- R12: In slave role with the select line high, miso_oe is 0 and SCK transitions change neither the flags nor the read buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address: 0 configuration, 1 status, 2 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| sck_o | output | 1 | Serial clock driven in master role |
| sck_oe | output | 1 | Drive enable for sck_o |
| sck_i | input | 1 | Serial clock received in slave role |
| mosi_o | output | 1 | Outgoing data in master role |
| mosi_oe | output | 1 | Drive enable for mosi_o |
| mosi_i | input | 1 | Incoming data in slave role |
| miso_o | output | 1 | Outgoing data in slave role |
| miso_oe | output | 1 | Drive enable for miso_o |
| miso_i | input | 1 | Incoming data in master role |
| ss_n_i | input | 1 | Active-low select input |

## Verification
In master role, the first SCK transition comes H cycles after the edge that took the data write. The frame-done flag follows 16·H cycles after that edge. The bench therefore samples the status bit 16·H−1 cycles and 16·H cycles after the write, on falling clock edges, and computes H from the rate code.

Slave inputs pass through two synchroniser stages and one edge-detect stage, so a slave reacts about three cycles after an SCK change. The bench keeps eight cycles per SCK period and reads MISO a half period after each change. It checks flags and buffers several cycles after the last edge.

A mode fault shows up three cycles after the select line falls, and the bench reads the registers four cycles later.

// File: rtl/spi_pkg.sv
package spi_pkg;

    localparam int FRAME_W = 8;
    localparam int HALF_W  = 7;

    typedef enum logic [1:0] {
        A_CFG  = 2'd0,
        A_STAT = 2'd1,
        A_DATA = 2'd2,
        A_NONE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic       mstr;
        logic       cpol;
        logic       cpha;
        logic [1:0] rate;
    } cfg_t;

    // half SCK period in system cycles for a rate code and double-speed bit
    function automatic logic [HALF_W-1:0] half_cycles(input logic [1:0] rate, input logic dbl);
        int e;
        case (rate)
            2'd0:    e = 1;
            2'd1:    e = 3;
            2'd2:    e = 5;
            default: e = 6;
        endcase
        if (dbl) e = e - 1;
        return HALF_W'(1) << e;
    endfunction

endpackage

// File: rtl/spi_clkgen.sv
module spi_clkgen #(
    parameter int HW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [HW-1:0] half,
    output logic          tick
);
    logic [HW-1:0] cnt_q;

    assign tick = run && (cnt_q == half - HW'(1));

    always_ff @(posedge clk) begin
        if (rst || !run) cnt_q <= '0;
        else if (tick)   cnt_q <= '0;
        else             cnt_q <= cnt_q + HW'(1);
    end
endmodule

// File: rtl/spi_slave_front.sv
module spi_slave_front #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sck_i,
    input  logic mosi_i,
    input  logic ss_n_i,
    output logic sck_edge,
    output logic mosi_s,
    output logic ss_n_s
);
    logic [STAGES-1:0] sck_p, mosi_p, ss_p;
    logic              sck_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_p  <= '0;
            mosi_p <= '0;
            ss_p   <= '1;
            sck_d  <= 1'b0;
        end else begin
            sck_p  <= {sck_p[STAGES-2:0], sck_i};
            mosi_p <= {mosi_p[STAGES-2:0], mosi_i};
            ss_p   <= {ss_p[STAGES-2:0], ss_n_i};
            sck_d  <= sck_p[STAGES-1];
        end
    end

    assign sck_edge = sck_p[STAGES-1] ^ sck_d;
    assign mosi_s   = mosi_p[STAGES-1];
    assign ss_n_s   = ss_p[STAGES-1];
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         edge_evt,
    input  logic         cpha,
    input  logic         din,
    output logic         dout,
    output logic         active,
    output logic         done,
    output logic [W-1:0] rx_word
);
    localparam int CW   = $clog2(2 * W);
    localparam int LAST = 2 * W - 1;

    logic [W-1:0]  tx_q, rx_q;
    logic [CW-1:0] cnt_q;
    logic          lead, smp, setup;

    // even edge counts are leading edges
    assign lead    = !cnt_q[0];
    assign smp     = edge_evt && (lead ^ cpha);
    assign setup   = edge_evt && !(lead ^ cpha);
    assign done    = edge_evt && (cnt_q == CW'(LAST)) && !clr;
    assign rx_word = smp ? {rx_q[W-2:0], din} : rx_q;
    assign dout    = tx_q[W-1];
    assign active  = cnt_q != '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q  <= '0;
            rx_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (clr) begin
                cnt_q <= '0;
            end else if (edge_evt) begin
                cnt_q <= done ? '0 : cnt_q + CW'(1);
                if (smp) rx_q <= {rx_q[W-2:0], din};
            end
            if (load)
                tx_q <= load_data;
            else if (setup && !clr && cnt_q != '0)
                tx_q <= {tx_q[W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/spi_port.sv
module spi_port
    import spi_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_sel,
    input  logic       bus_wr,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       sck_o,
    output logic       sck_oe,
    input  logic       sck_i,
    output logic       mosi_o,
    output logic       mosi_oe,
    input  logic       mosi_i,
    output logic       miso_o,
    output logic       miso_oe,
    input  logic       miso_i,
    input  logic       ss_n_i
);
    cfg_t               cfg_q;
    logic               dbl_q, spif_q, wcol_q, armed_q, busy_m, sck_ph;
    logic [FRAME_W-1:0] rx_buf;
    logic               mstr_q, cpol;

    logic [HALF_W-1:0]  half;
    logic               tick, sck_edge, mosi_s, ss_n_s;
    logic               ss_lo, fault, slave_sel, edge_evt, clr, din;
    logic               sh_dout, sh_active, done;
    logic [FRAME_W-1:0] rx_word;
    logic               wr_cfg, wr_stat, wr_data, rd_stat, data_acc, ongoing, load, start;

    assign mstr_q = cfg_q.mstr;
    assign cpol   = cfg_q.cpol;
    assign half   = half_cycles(cfg_q.rate, dbl_q);

    assign wr_cfg   = bus_sel && bus_wr  && bus_addr == A_CFG;
    assign wr_stat  = bus_sel && bus_wr  && bus_addr == A_STAT;
    assign wr_data  = bus_sel && bus_wr  && bus_addr == A_DATA;
    assign rd_stat  = bus_sel && !bus_wr && bus_addr == A_STAT;
    assign data_acc = bus_sel && bus_addr == A_DATA;

    assign ss_lo     = !ss_n_s;
    assign fault     = mstr_q && ss_lo;
    assign slave_sel = !mstr_q && ss_lo;
    assign ongoing   = busy_m || sh_active;
    assign load      = wr_data && !ongoing;
    assign start     = load && mstr_q && !fault;
    assign edge_evt  = mstr_q ? (busy_m && tick && !fault) : (slave_sel && sck_edge);
    assign clr       = mstr_q ? fault : !slave_sel;
    assign din       = mstr_q ? miso_i : mosi_s;

    spi_clkgen #(.HW(HALF_W)) u_clkgen (
        .clk  (clk),
        .rst  (rst),
        .run  (busy_m),
        .half (half),
        .tick (tick)
    );

    spi_slave_front #(.STAGES(2)) u_front (
        .clk      (clk),
        .rst      (rst),
        .sck_i    (sck_i),
        .mosi_i   (mosi_i),
        .ss_n_i   (ss_n_i),
        .sck_edge (sck_edge),
        .mosi_s   (mosi_s),
        .ss_n_s   (ss_n_s)
    );

    spi_shifter #(.W(FRAME_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .load      (load),
        .load_data (bus_wdata),
        .edge_evt  (edge_evt),
        .cpha      (cfg_q.cpha),
        .din       (din),
        .dout      (sh_dout),
        .active    (sh_active),
        .done      (done),
        .rx_word   (rx_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            dbl_q   <= 1'b0;
            spif_q  <= 1'b0;
            wcol_q  <= 1'b0;
            armed_q <= 1'b0;
            busy_m  <= 1'b0;
            sck_ph  <= 1'b0;
            rx_buf  <= '0;
        end else begin
            if (wr_cfg) cfg_q <= cfg_t'(bus_wdata[4:0]);
            if (fault)  cfg_q.mstr <= 1'b0;
            if (wr_stat) dbl_q <= bus_wdata[0];

            if (fault || !mstr_q) busy_m <= 1'b0;
            else if (start)       busy_m <= 1'b1;
            else if (done)        busy_m <= 1'b0;

            if (fault || !mstr_q) sck_ph <= 1'b0;
            else if (edge_evt)    sck_ph <= !sck_ph;

            if (done) rx_buf <= rx_word;

            if (data_acc)                   armed_q <= 1'b0;
            else if (rd_stat && (spif_q || wcol_q)) armed_q <= 1'b1;

            if (done || fault)             spif_q <= 1'b1;
            else if (armed_q && data_acc)  spif_q <= 1'b0;

            if (wr_data && ongoing)        wcol_q <= 1'b1;
            else if (armed_q && data_acc)  wcol_q <= 1'b0;
        end
    end

    always_comb begin
        case (bus_addr)
            A_CFG:   bus_rdata = {3'b000, cfg_q};
            A_STAT:  bus_rdata = {spif_q, wcol_q, 5'b00000, dbl_q};
            A_DATA:  bus_rdata = rx_buf;
            default: bus_rdata = 8'h00;
        endcase
    end

    assign sck_o   = sck_ph ^ cpol;
    assign sck_oe  = mstr_q;
    assign mosi_o  = sh_dout;
    assign mosi_oe = mstr_q;
    assign miso_o  = sh_dout;
    assign miso_oe = slave_sel;
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
    input logic clk,
    input logic rst,
    input logic mstr,
    input logic cpol,
    input logic fault,
    input logic busy_m,
    input logic ongoing,
    input logic spif,
    input logic wcol,
    input logic wr_data,
    input logic armed,
    input logic data_acc,
    input logic done,
    input logic sck_o,
    input logic miso_oe,
    input logic mosi_oe
);
    p_fault_r10: assert property (@(posedge clk) disable iff (rst)
        fault |=> (!mstr && spif));

    p_collide_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_data && ongoing) |=> wcol);

    p_flag_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (armed && data_acc && !done && !fault && !(wr_data && ongoing)) |=> (!spif && !wcol));

    p_done_flag_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> spif);

    p_drive_excl_r12: assert property (@(posedge clk) disable iff (rst)
        !(miso_oe && mosi_oe));

    p_idle_sck_r5: assert property (@(posedge clk) disable iff (rst)
        (mstr && !busy_m && $past(mstr && !busy_m) && $stable(cpol)) |-> $stable(sck_o));
endmodule

bind spi_port spi_port_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .mstr     (mstr_q),
    .cpol     (cpol),
    .fault    (fault),
    .busy_m   (busy_m),
    .ongoing  (ongoing),
    .spif     (spif_q),
    .wcol     (wcol_q),
    .wr_data  (wr_data),
    .armed    (armed_q),
    .data_acc (data_acc),
    .done     (done),
    .sck_o    (sck_o),
    .miso_oe  (miso_oe),
    .mosi_oe  (mosi_oe)
);

// File: tb/spi_port_tb.sv
module spi_port_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd3;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, miso_i;
    logic       sck_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    bit       mon_on = 0, cpol_tb = 0, cpha_tb = 0, sck_prev = 0;
    logic [7:0] mon_mosi = 0, sbyte = 0;
    int       edge_cnt = 0, sidx = 0;

    always #10 clk = !clk;

    spi_port u_dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck_o(sck_o), .sck_oe(sck_oe),
        .sck_i(sck_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe), .mosi_i(mosi_i),
        .miso_o(miso_o), .miso_oe(miso_oe), .miso_i(miso_i), .ss_n_i(ss_n_i)
    );

    // bench-side slave model for master frames
    assign miso_i = (mon_on && sidx < 8) ? sbyte[7 - sidx] : 1'b0;

    always @(negedge clk) begin
        if (mon_on && sck_o != sck_prev) begin
            if ((sck_o != cpol_tb) ^ cpha_tb)
                mon_mosi = {mon_mosi[6:0], mosi_o};
            else if (!(cpha_tb && edge_cnt == 0))
                sidx = sidx + 1;
            edge_cnt = edge_cnt + 1;
        end
        sck_prev = sck_o;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic clear_flags();
        logic [7:0] t;
        rd(2'd1, t);
        rd(2'd2, t);
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, tx, m, s, got;
        int h, e;
        wait_n(4);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        peek(2'd0, d); chk(d == 8'h00, "R1 cfg", d, 0);
        peek(2'd1, d); chk(d == 8'h00, "R1 status", d, 0);
        peek(2'd2, d); chk(d == 8'h00, "R1 data", d, 0);
        chk({sck_o, sck_oe, mosi_oe, miso_oe} == 4'b0, "R1 pins", {sck_o, sck_oe, mosi_oe, miso_oe}, 0);

        // R2 / R3 register layout
        wr(2'd0, 8'hFF);
        peek(2'd0, d); chk(d == 8'h1F, "R2 cfg readback", d, 8'h1F);
        wr(2'd0, 8'h0A);
        peek(2'd0, d); chk(d == 8'h0A, "R2 cfg fields", d, 8'h0A);
        wr(2'd1, 8'hFF);
        peek(2'd1, d); chk(d == 8'h01, "R3 status readback", d, 8'h01);
        wr(2'd1, 8'h00);
        peek(2'd1, d); chk(d == 8'h00, "R3 dbl cleared", d, 0);

        // R4 R5 R6 R7 master sweep over all rate / speed / mode settings
        for (int cfg = 0; cfg < 32; cfg++) begin
            logic [1:0] rate;
            logic       dbl;
            rate = cfg[1:0]; dbl = cfg[2]; cpha_tb = cfg[3]; cpol_tb = cfg[4];
            e = (rate == 2'd3) ? 6 : 2 * rate + 1;
            if (dbl) e = e - 1;
            h = 1 << e;
            tx = 8'hA5 ^ 8'(cfg * 37);
            sbyte = 8'h3C ^ 8'(cfg * 91);
            wr(2'd1, {7'd0, dbl});
            wr(2'd0, {3'b000, 1'b1, cpol_tb, cpha_tb, rate});
            @(negedge clk);
            chk(sck_o == cpol_tb, "R5 rest level", sck_o, cpol_tb);
            mon_mosi = 0; edge_cnt = 0; sidx = 0; sck_prev = sck_o; mon_on = 1;
            wr(2'd2, tx);
            wait_n(16 * h - 1);
            peek(2'd1, d); chk(d[7] == 1'b0, "R4 flag early", d[7], 0);
            @(negedge clk); #2;
            peek(2'd1, d); chk(d[7] == 1'b1, "R4 flag due", d[7], 1);
            chk(edge_cnt == 16, "R5 edge count", edge_cnt, 16);
            chk(sck_o == cpol_tb, "R5 rest after", sck_o, cpol_tb);
            chk(mon_mosi == tx, "R6 mosi bits", mon_mosi, tx);
            peek(2'd2, d); chk(d == sbyte, "R7 rx buffer", d, sbyte);
            mon_on = 0;
            clear_flags();
        end

        // R8 collision during a master frame, R9 flag clearing
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h13);
        cpol_tb = 0; cpha_tb = 0; sbyte = 8'h5A;
        mon_mosi = 0; edge_cnt = 0; sidx = 0; sck_prev = sck_o; mon_on = 1;
        wr(2'd2, 8'h96);
        wait_n(10);
        wr(2'd2, 8'h11);
        peek(2'd1, d); chk(d[6] == 1'b1, "R8 collision flag", d[6], 1);
        wait_n(16 * 64);
        #2;
        chk(mon_mosi == 8'h96, "R8 frame unchanged", mon_mosi, 8'h96);
        mon_on = 0;
        rd(2'd2, d);
        peek(2'd1, d); chk(d[7:6] == 2'b11, "R9 no clear without status read", d[7:6], 3);
        clear_flags();
        peek(2'd1, d); chk(d[7:6] == 2'b00, "R9 flags cleared", d[7:6], 0);

        // R10 mode fault
        ss_n_i = 0;
        wait_n(4);
        peek(2'd0, d); chk(d[4] == 1'b0, "R10 role dropped", d[4], 0);
        peek(2'd1, d); chk(d[7] == 1'b1, "R10 flag set", d[7], 1);
        chk(sck_oe == 1'b0 && mosi_oe == 1'b0, "R10 drive released", {sck_oe, mosi_oe}, 0);
        ss_n_i = 1;
        wait_n(4);
        peek(2'd0, d); chk(d[4] == 1'b0, "R10 stays slave", d[4], 0);
        clear_flags();

        // R11 slave frames in all four modes
        for (int md = 0; md < 4; md++) begin
            logic cp, ch;
            cp = md[1]; ch = md[0];
            m = 8'hC3 ^ 8'(md * 29);
            s = 8'h6E ^ 8'(md * 53);
            sck_i = cp;
            wr(2'd0, {3'b000, 1'b0, cp, ch, 2'b00});
            wr(2'd2, s);
            ss_n_i = 0;
            wait_n(4);
            chk(miso_oe == 1'b1, "R11 miso driven", miso_oe, 1);
            for (int b = 7; b >= 0; b--) begin
                if (!ch) begin
                    mosi_i = m[b];
                    wait_n(4);
                    got[b] = miso_o;
                    sck_i = !cp;
                    wait_n(4);
                    sck_i = cp;
                end else begin
                    sck_i = !cp;
                    mosi_i = m[b];
                    wait_n(4);
                    got[b] = miso_o;
                    sck_i = cp;
                    wait_n(4);
                end
            end
            wait_n(6);
            peek(2'd1, d); chk(d[7] == 1'b1, "R11 slave done", d[7], 1);
            peek(2'd2, d); chk(d == m, "R11 slave rx", d, m);
            chk(got == s, "R11 slave tx", got, s);
            ss_n_i = 1;
            wait_n(4);
            chk(miso_oe == 1'b0, "R12 miso released", miso_oe, 0);
            clear_flags();
        end

        // R12 SCK ignored while deselected
        sck_i = 0;
        wr(2'd0, 8'h00);
        for (int k = 0; k < 16; k++) begin
            sck_i = !sck_i;
            mosi_i = k[0];
            wait_n(4);
            chk(miso_oe == 1'b0, "R12 miso off", miso_oe, 0);
        end
        wait_n(4);
        peek(2'd1, d); chk(d[7:6] == 2'b00, "R12 flags untouched", d[7:6], 0);
        peek(2'd2, d); chk(d == m, "R12 buffer untouched", d, m);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        finished = 1;
        $finish;
    end
endmodule